// File: doc/BRIEF.md
# APB Address Decoder with Built-in Error Responder

This block sits between a single APB manager and three subordinates. It decodes a region field of the manager's address into one select line per subordinate. Every address outside the mapped regions goes to a small error responder inside the block, so that access finishes with an error response and the bus never hangs. The enable strobe goes to all subordinates on one shared wire. The ready, read-data and error returns are chosen by the same one-hot select that drove the request.

The select vector, the address and the write flag are captured in registers on the clock edge that closes the manager's setup cycle. They stay frozen until the access completes. The subordinate side therefore sees a clean setup cycle followed by an access phase, driven only from settled registers. Any change on the manager's address lines cannot glitch a select. The registering costs one cycle per transfer: the manager sees one more wait state than the subordinate inserts.

Top module: `apbdec_fabric`

## Requirements
- R1: For address bits [15:12] equal to 0x2, 0x3 or 0x4, exactly `s_psel[0]`, `s_psel[1]` or `s_psel[2]` is raised, in that order. Address bits outside [15:12] do not affect the decode.
- R2: Any other value of bits [15:12] raises no `s_psel` bit. The access then completes in its first subordinate access cycle with `m_pready`=1, `m_pslverr`=1 and `m_prdata` all zeros.
- R3: While no transfer is captured, `s_psel` is all zeros, and `s_penable`, `m_pready` and `m_pslverr` are low, whatever the manager drives on `m_paddr`.
- R4: A transfer is captured on the rising edge at which `m_psel`=1 and `m_penable`=0. The following cycle shows the chosen select high with `s_penable` low. The cycle after that raises `s_penable`. A subordinate that is ready at once therefore completes on the manager's second enable cycle, and each subordinate wait cycle adds one cycle.
- R5: From capture to completion, `s_psel`, `s_paddr` and `s_pwrite` hold the values captured at setup, even if `m_paddr` changes in the meantime.
- R6: `m_pready`, `m_prdata` and `m_pslverr` come only from the selected responder. The returns of unselected subordinates have no effect, and `m_pready` is low whenever `s_penable` is low.
- R7: In the cycle after a completion (`m_pready`=1), `s_psel` and `s_penable` are low together.
- R8: An active-low synchronous reset clears every select, `s_penable` and the captured transfer. This includes a reset in the middle of an access.
- R9: `s_paddr` and `s_pwrite` carry the manager's address and write flag as captured at setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| m_paddr | input | AW | Manager address |
| m_psel | input | 1 | Manager select |
| m_penable | input | 1 | Manager enable |
| m_pwrite | input | 1 | Manager write flag |
| m_prdata | output | DW | Read data returned to the manager |
| m_pready | output | 1 | Completion returned to the manager |
| m_pslverr | output | 1 | Error returned to the manager |
| s_psel | output | NSUB | One select per subordinate |
| s_penable | output | 1 | Enable shared by all subordinates |
| s_paddr | output | AW | Captured address to subordinates |
| s_pwrite | output | 1 | Captured write flag to subordinates |
| s_prdata | input | NSUB*DW | Read data of all subordinates, subordinate i at bits [i*DW +: DW] |
| s_pready | input | NSUB | Ready of each subordinate |
| s_pslverr | input | NSUB | Error of each subordinate |

## Verification
The bench builds the block with its defaults: 32-bit address and data, three subordinates, region field [15:12], first mapped region 0x2. Its subordinate models insert 0, 1 and 2 wait cycles, so one run covers the pass-through latency and two stretched ones. Unselected models drive ready, error and a marker word on purpose, so any leak through the return mux shows up. Addresses with upper bits set outside the field, the regions just below and above the map, a mid-access address change and a reset during an access are all reachable with these values.

// File: rtl/apbdec_pkg.sv
package apbdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } phase_e;
endpackage

// File: rtl/apbdec_region_match.sv
module apbdec_region_match #(
    parameter int REG_W        = 4,
    parameter int NSUB         = 3,
    parameter int FIRST_REGION = 2
) (
    input  logic [REG_W-1:0] region,
    output logic [NSUB:0]    hit_oh
);
    for (genvar i = 0; i < NSUB; i++) begin : g_cmp
        localparam logic [REG_W-1:0] CODE = REG_W'(FIRST_REGION + i);
        assign hit_oh[i] = (region == CODE);
    end
    // highest bit: nothing mapped here, route to the error responder
    assign hit_oh[NSUB] = ~|hit_oh[NSUB-1:0];
endmodule

// File: rtl/apbdec_ctrl.sv
module apbdec_ctrl
    import apbdec_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NRESP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_psel,
    input  logic             m_penable,
    input  logic             m_pwrite,
    input  logic [AW-1:0]    m_paddr,
    input  logic [NRESP-1:0] hit_oh,
    input  logic             ret_ready,
    output phase_e           phase,
    output logic [NRESP-1:0] sel_oh,
    output logic [AW-1:0]    addr_q,
    output logic             write_q
);
    typedef struct packed {
        phase_e           phase;
        logic [NRESP-1:0] sel;
        logic [AW-1:0]    addr;
        logic             write;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            ST_IDLE: begin
                if (m_psel && !m_penable) begin
                    ctl_d.phase = ST_SETUP;
                    ctl_d.sel   = hit_oh;
                    ctl_d.addr  = m_paddr;
                    ctl_d.write = m_pwrite;
                end
            end
            ST_SETUP: begin
                ctl_d.phase = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (ret_ready) begin
                    ctl_d.phase = ST_IDLE;
                    ctl_d.sel   = '0;
                end
            end
            default: begin
                ctl_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase   = ctl_q.phase;
    assign sel_oh  = ctl_q.sel;
    assign addr_q  = ctl_q.addr;
    assign write_q = ctl_q.write;
endmodule

// File: rtl/apbdec_ret_mux.sv
module apbdec_ret_mux #(
    parameter int NSUB = 3,
    parameter int DW   = 32
) (
    input  logic [NSUB:0]      sel_oh,
    input  logic [NSUB-1:0]    sub_ready,
    input  logic [NSUB*DW-1:0] sub_rdata,
    input  logic [NSUB-1:0]    sub_err,
    output logic               ret_ready,
    output logic [DW-1:0]      ret_rdata,
    output logic               ret_err
);
    always_comb begin
        // error responder: ready at once, error flagged, data zero
        ret_ready = sel_oh[NSUB];
        ret_err   = sel_oh[NSUB];
        ret_rdata = '0;
        for (int i = 0; i < NSUB; i++) begin
            ret_ready = ret_ready | (sel_oh[i] & sub_ready[i]);
            ret_err   = ret_err   | (sel_oh[i] & sub_err[i]);
            ret_rdata = ret_rdata | ({DW{sel_oh[i]}} & sub_rdata[i*DW +: DW]);
        end
    end
endmodule

// File: rtl/apbdec_fabric.sv
module apbdec_fabric
    import apbdec_pkg::*;
#(
    parameter int AW           = 32,
    parameter int DW           = 32,
    parameter int NSUB         = 3,
    parameter int REG_LO       = 12,
    parameter int REG_W        = 4,
    parameter int FIRST_REGION = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic [AW-1:0]      m_paddr,
    input  logic               m_psel,
    input  logic               m_penable,
    input  logic               m_pwrite,
    output logic [DW-1:0]      m_prdata,
    output logic               m_pready,
    output logic               m_pslverr,
    output logic [NSUB-1:0]    s_psel,
    output logic               s_penable,
    output logic [AW-1:0]      s_paddr,
    output logic               s_pwrite,
    input  logic [NSUB*DW-1:0] s_prdata,
    input  logic [NSUB-1:0]    s_pready,
    input  logic [NSUB-1:0]    s_pslverr
);
    localparam int NRESP = NSUB + 1;

    logic [NRESP-1:0] hit_oh;
    logic [NRESP-1:0] sel_all;
    phase_e           phase;
    logic             ret_ready;
    logic             ret_err;
    logic [DW-1:0]    ret_rdata;
    logic             in_access;

    apbdec_region_match #(
        .REG_W(REG_W), .NSUB(NSUB), .FIRST_REGION(FIRST_REGION)
    ) u_match (
        .region (m_paddr[REG_LO +: REG_W]),
        .hit_oh (hit_oh)
    );

    apbdec_ctrl #(.AW(AW), .NRESP(NRESP)) u_ctrl (
        .clk       (pclk),
        .rst_n     (presetn),
        .m_psel    (m_psel),
        .m_penable (m_penable),
        .m_pwrite  (m_pwrite),
        .m_paddr   (m_paddr),
        .hit_oh    (hit_oh),
        .ret_ready (ret_ready),
        .phase     (phase),
        .sel_oh    (sel_all),
        .addr_q    (s_paddr),
        .write_q   (s_pwrite)
    );

    apbdec_ret_mux #(.NSUB(NSUB), .DW(DW)) u_ret (
        .sel_oh    (sel_all),
        .sub_ready (s_pready),
        .sub_rdata (s_prdata),
        .sub_err   (s_pslverr),
        .ret_ready (ret_ready),
        .ret_rdata (ret_rdata),
        .ret_err   (ret_err)
    );

    assign in_access = (phase == ST_ACCESS);
    assign s_psel    = sel_all[NSUB-1:0];
    assign s_penable = in_access;
    assign m_pready  = in_access & ret_ready;
    assign m_pslverr = in_access & ret_err;
    assign m_prdata  = in_access ? ret_rdata : '0;
endmodule

// File: rtl/apbdec_fabric_chk.sv
module apbdec_fabric_chk
    import apbdec_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NSUB = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSUB:0]   sel_all,
    input phase_e          phase,
    input logic [NSUB-1:0] s_psel,
    input logic            s_penable,
    input logic [AW-1:0]   s_paddr,
    input logic            m_pready,
    input logic            m_pslverr,
    input logic [DW-1:0]   m_prdata
);
    // R1: never more than one responder owns the bus
    a_r1_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_all));

    // R1/R2: a captured transfer always has exactly one owner
    a_r1_busy_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE) |-> $onehot(sel_all));

    // R3: idle means silence on both sides
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE) |-> (sel_all == '0 && !s_penable && !m_pready));

    // R4: enable rises only after a select-only cycle, with the select unchanged
    a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_penable) |-> ($past(sel_all) != '0 && $stable(sel_all)));

    // R5: owner and address frozen while the access runs
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_penable |-> ($stable(sel_all) && $stable(s_paddr)));

    // R7: select and enable fall in the same cycle after completion
    a_r7_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
        m_pready |=> (s_psel == '0 && !s_penable));

    // R2: error responder answers at once with an error and zero data
    a_r2_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (s_penable && sel_all[NSUB]) |-> (m_pready && m_pslverr && m_prdata == '0));

    // R6: no completion or error reaches the manager outside the access phase
    a_r6_no_stray_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !s_penable |-> (!m_pready && !m_pslverr));
endmodule

bind apbdec_fabric apbdec_fabric_chk #(.AW(AW), .DW(DW), .NSUB(NSUB)) u_chk (
    .clk       (pclk),
    .rst_n     (presetn),
    .sel_all   (sel_all),
    .phase     (phase),
    .s_psel    (s_psel),
    .s_penable (s_penable),
    .s_paddr   (s_paddr),
    .m_pready  (m_pready),
    .m_pslverr (m_pslverr),
    .m_prdata  (m_prdata)
);

// File: tb/apbdec_fabric_tb.sv
module apbdec_fabric_tb;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int NSUB = 3;

    logic               clk = 1'b0;
    logic               presetn;
    logic [AW-1:0]      m_paddr;
    logic               m_psel, m_penable, m_pwrite;
    logic [DW-1:0]      m_prdata;
    logic               m_pready, m_pslverr;
    logic [NSUB-1:0]    s_psel;
    logic               s_penable;
    logic [AW-1:0]      s_paddr;
    logic               s_pwrite;
    logic [NSUB*DW-1:0] s_prdata;
    logic [NSUB-1:0]    s_pready, s_pslverr;

    always #10 clk = ~clk;  // 50 MHz

    apbdec_fabric u_dut (
        .pclk(clk), .presetn(presetn),
        .m_paddr(m_paddr), .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr),
        .s_psel(s_psel), .s_penable(s_penable), .s_paddr(s_paddr), .s_pwrite(s_pwrite),
        .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr)
    );

    function automatic logic [31:0] sub_data(int idx, logic [31:0] a);
        return {8'hA0 + 8'(idx), 8'h5A, a[15:0]};
    endfunction

    // subordinate models: sub g waits g cycles; when unselected they drive junk
    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        int   cnt;
        logic act;
        assign act = s_psel[g] & s_penable;
        always @(posedge clk) begin
            if (!act) cnt <= 0;
            else if (cnt < g) cnt <= cnt + 1;
        end
        assign s_pready[g]            = act ? (cnt == g) : 1'b1;
        assign s_prdata[g*DW +: DW]   = act ? sub_data(g, s_paddr) : (32'hDEAD_0000 | 32'(g));
        assign s_pslverr[g]           = act ? (s_paddr[7:0] == 8'hEE) : 1'b1;
    end

    typedef struct {
        logic [31:0]     addr;
        logic            wr;
        logic [31:0]     rdata;
        logic            err;
        int              lat;
        logic [NSUB-1:0] sel;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   acc    = 0;
    bit   post   = 0;

    task automatic chk(string req, bit ok, logic [63:0] actv, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, actv, expv, $time);
        end
    endtask

    // driver: builds expected item from the requirements, then runs the transfer
    task automatic xfer(logic [31:0] a, logic wr, bit change, logic [31:0] alt);
        exp_t e;
        logic [3:0] rg;
        rg     = a[15:12];
        e.addr = a;
        e.wr   = wr;
        if (rg >= 4'h2 && rg <= 4'h4) begin
            e.sel   = NSUB'(1) << (rg - 4'h2);
            e.rdata = sub_data(int'(rg) - 2, a);
            e.err   = (a[7:0] == 8'hEE);
            e.lat   = 2 + int'(rg) - 2;
        end else begin
            e.sel   = '0;
            e.rdata = '0;
            e.err   = 1'b1;
            e.lat   = 2;
        end
        @(negedge clk);
        m_psel = 1; m_penable = 0; m_paddr = a; m_pwrite = wr;
        q.push_back(e);
        @(negedge clk);
        m_penable = 1;
        if (change) m_paddr = alt;
        while (1) begin
            #5;
            if (m_pready) break;
            @(negedge clk);
        end
        @(negedge clk);
        m_psel = 0; m_penable = 0; m_paddr = 32'h0000_3000;
    endtask

    // monitor: pops expected items as the design completes transfers
    always @(negedge clk) begin
        #5;
        if (post) begin
            chk("R7 select/enable drop together", s_psel == '0 && !s_penable,
                {s_psel, s_penable}, 0);
            post = 0;
        end
        if (!presetn) begin
            acc = 0;
        end else if (m_psel && m_penable) begin
            acc++;
            if (acc == 1 && q.size() > 0)
                chk("R4 setup cycle select-only", s_psel == q[0].sel && !s_penable,
                    {s_psel, s_penable}, {q[0].sel, 1'b0});
            if (m_pready) begin
                if (q.size() == 0) begin
                    chk("R6 unexpected completion", 0, 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.sel == 0 ? "R2 no subordinate select" : "R1 select routing",
                        s_psel == e.sel && s_penable, {s_psel, s_penable}, {e.sel, 1'b1});
                    chk(e.sel == 0 ? "R2 error data zero" : "R6 read data",
                        m_prdata == e.rdata, m_prdata, e.rdata);
                    chk(e.sel == 0 ? "R2 error flag" : "R6 error flag",
                        m_pslverr == e.err, m_pslverr, e.err);
                    chk("R4 latency", acc == e.lat, acc, e.lat);
                    chk("R9 address copy (R5 held)", s_paddr == e.addr, s_paddr, e.addr);
                    chk("R9 write copy", s_pwrite == e.wr, s_pwrite, e.wr);
                end
                acc  = 0;
                post = 1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        presetn = 0; m_psel = 1; m_penable = 0; m_pwrite = 0; m_paddr = 32'h0000_2000;
        repeat (3) @(negedge clk);
        #5;
        chk("R8 reset state", s_psel == '0 && !s_penable && !m_pready && !m_pslverr,
            {s_psel, s_penable, m_pready, m_pslverr}, 0);
        @(negedge clk);
        m_psel = 0; presetn = 1;

        // R3: idle with a mapped address on the lines
        m_paddr = 32'h0000_2000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #5;
            chk("R3 idle quiet", s_psel == '0 && !s_penable && !m_pready,
                {s_psel, s_penable, m_pready}, 0);
        end

        xfer(32'h0000_2004, 0, 0, 0);      // R1 sub0, no wait
        xfer(32'h0000_3010, 0, 0, 0);      // R1 sub1, one wait
        xfer(32'h0000_4020, 1, 0, 0);      // R1 sub2, two waits, write
        xfer(32'h0000_1800, 0, 0, 0);      // R2 below map
        xfer(32'h0000_5000, 1, 0, 0);      // R2 above map
        xfer(32'h0000_0000, 0, 0, 0);      // R2 region 0
        xfer(32'hFFFF_F0EE, 0, 0, 0);      // R2 region F
        xfer(32'h0001_2100, 0, 0, 0);      // R1 upper bits ignored
        xfer(32'h0000_30EE, 1, 0, 0);      // R6 subordinate error passes
        xfer(32'h0000_2008, 0, 1, 32'h0000_4000);  // R5 address changes mid access
        xfer(32'h0000_4ABC, 0, 1, 32'h0000_1000);  // R5 to an unmapped region

        // R8: reset in the middle of an access
        @(negedge clk);
        m_psel = 1; m_penable = 0; m_paddr = 32'h0000_4000;
        @(negedge clk);
        m_penable = 1; presetn = 0;
        @(negedge clk); #5;
        chk("R8 reset mid access", s_psel == '0 && !s_penable && !m_pready,
            {s_psel, s_penable, m_pready}, 0);
        @(negedge clk);
        m_psel = 0; m_penable = 0; presetn = 1;
        xfer(32'h0000_3004, 0, 0, 0);      // R1 clean transfer after reset

        repeat (3) @(negedge clk);
        chk("R6 all expected completions seen", q.size() == 0, q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule